// File: doc/BRIEF.md
# Block Transfer Sequencer

This block carries out one multiple-register load or store. Given a 16-entry register selection mask, a base address and a few mode bits, it visits every selected register one by one. For each one it issues a single 32-bit memory request and moves data between memory and a register-file port. That port carries a bank selector next to the register index. The walk runs either upward (index 0 to 15, address stepping by +4 before each access) or downward (index 15 to 0, stepping by -4 before each access).

A data abort reported by memory ends the walk at once, and the aborted register is left untouched. The block then presents a one-cycle completion pulse with the abort flag, the number of registers actually moved and, if enabled and no abort occurred, a base-update value. The user bank can be targeted without changing the processor mode. When program-counter (index 15) loads occur in the legacy 26-bit mode, only the address field of that register is replaced.

The FSM has three states. `ST_IDLE` waits for `start`. `ST_XFER` issues the requests: it stays while memory is not ready and loops for each remaining register. `ST_DONE` presents the results for one cycle. There are four transitions. IDLE→XFER happens on start with a non-empty list. IDLE→DONE happens on start with an empty list. XFER→DONE happens on the last accepted access or on an abort. DONE→IDLE always follows.

Top module: `ldm_seq`

## Requirements
- R1: With `op_incr`=1 the registers are visited in ascending index order, and the k-th access (k from 0) uses address `base_addr + 4*(k+1)`.
- R2: With `op_incr`=0 the registers are visited in descending index order, and the k-th access uses address `base_addr - 4*(k+1)`.
- R3: Exactly one memory request is made per selected register. `mem_req` stays high with `mem_addr`, `mem_we` and `rf_rd_idx` stable until `mem_ready` is seen.
- R4: On an accepted load, `rf_wr_en` pulses that cycle with `rf_wr_idx` equal to the request's index and `rf_wr_data` equal to `mem_rdata`. On a store, `mem_we`=1, `mem_wdata` equals `rf_rd_data` and `rf_wr_en` stays 0.
- R5: When `mem_ready` and `mem_abort` are both high, no register is written. No further request is made, and `done` with `aborted`=1 follows in the next cycle.
- R6: `wb_en` is high in the done cycle only when `op_wb`=1 and no abort occurred. `wb_addr` then equals `base_addr ± 4*N`, where N is the number of selected registers.
- R7: When `op_user`=1 and bit 15 of `reg_list` is 0, `rf_rd_mode` and `rf_wr_mode` equal `USER_MODE` (5'h10). Otherwise they equal `cur_mode` as captured at start.
- R8: A load of index 15 with `op_user`=0 and `mode32`=0 writes `(old & ~32'h03FFFFFC) | (mem_rdata & 32'h03FFFFFC)`, where old is `rf_rd_data`. Any other index-15 load writes the whole word.
- R9: In the done cycle, `xfer_count` equals the number of registers moved: N without abort, or the number of accesses accepted before the aborted one.
- R10: An empty `reg_list` gives `done` in the cycle after start, with `xfer_count`=0 and no memory request.
- R11: `done` is a single-cycle pulse. After reset there is no request, no write and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in idle) |
| op_load | input | 1 | 1 = load, 0 = store |
| op_incr | input | 1 | 1 = ascending walk, 0 = descending |
| op_user | input | 1 | User-bank / whole-PC-load qualifier |
| op_wb | input | 1 | Request base update |
| mode32 | input | 1 | 1 = 32-bit address mode, 0 = 26-bit |
| reg_list | input | 16 | Register selection mask |
| base_addr | input | 32 | Base address |
| cur_mode | input | 5 | Current processor mode |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_mode | output | 5 | Register-file read bank |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_mode | output | 5 | Register-file write bank |
| rf_wr_data | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 32 | Memory read data |
| mem_abort | input | 1 | Data abort, valid with mem_ready |
| done | output | 1 | Completion pulse |
| aborted | output | 1 | Abort indication, valid with done |
| xfer_count | output | 5 | Registers moved, valid with done |
| wb_en | output | 1 | Base update enable, valid with done |
| wb_addr | output | 32 | Base update value |

## Verification
The hardest situation to reach is an abort that lands partway through a long list while memory is also stalling. That case needs a register already written, one refused and others still pending, all with the base update requested. The stimulus picks a random abort position within each list and holds off `mem_ready` at random. Directed cases place the abort on the first and on the index-15 access. The 26-bit program-counter merge needs index 15 selected with the qualifier clear and `mode32` low. A full-list load covers it directly, and the bench's register-file model returns words with bits set outside the address mask so that a wrong merge is visible.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } ldm_state_e;
endpackage

// File: rtl/ldm_pick.sv
module ldm_pick #(
    parameter int NREGS = 16,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] mask,
    input  logic             ascend,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [IDX_W-1:0] lo_idx, hi_idx;

    // lowest set bit: scan downward so the last hit is the smallest index
    always_comb begin
        lo_idx = '0;
        for (int i = NREGS - 1; i >= 0; i--) begin
            if (mask[i]) lo_idx = IDX_W'(i);
        end
    end

    // highest set bit: scan upward so the last hit is the largest index
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (mask[i]) hi_idx = IDX_W'(i);
        end
    end

    assign idx = ascend ? lo_idx : hi_idx;
    assign any = |mask;
endmodule

// File: rtl/ldm_pc_merge.sv
module ldm_pc_merge #(
    parameter int          DW      = 32,
    parameter logic [31:0] PC_MASK = 32'h03FF_FFFC
) (
    input  logic          partial,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    output logic [DW-1:0] merged
);
    localparam logic [DW-1:0] M = DW'(PC_MASK);

    assign merged = partial ? ((old_val & ~M) | (new_val & M)) : new_val;
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
    import ldm_pkg::*;
#(
    parameter int          NREGS     = 16,
    parameter int          DW        = 32,
    parameter int          AW        = 32,
    parameter int          MODE_W    = 5,
    parameter logic [4:0]  USER_MODE = 5'h10,
    parameter logic [31:0] PC_MASK   = 32'h03FF_FFFC,
    parameter int          STEP      = 4,
    localparam int         IDX_W     = $clog2(NREGS),
    localparam int         CNT_W     = $clog2(NREGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_load,
    input  logic              op_incr,
    input  logic              op_user,
    input  logic              op_wb,
    input  logic              mode32,
    input  logic [NREGS-1:0]  reg_list,
    input  logic [AW-1:0]     base_addr,
    input  logic [MODE_W-1:0] cur_mode,
    output logic [IDX_W-1:0]  rf_rd_idx,
    output logic [MODE_W-1:0] rf_rd_mode,
    input  logic [DW-1:0]     rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [MODE_W-1:0] rf_wr_mode,
    output logic [DW-1:0]     rf_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ready,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_abort,
    output logic              done,
    output logic              aborted,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              wb_en,
    output logic [AW-1:0]     wb_addr
);
    localparam int PC_IDX = NREGS - 1;

    ldm_state_e state_q, state_d;

    logic [NREGS-1:0]  pend_q;
    logic [AW-1:0]     addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              abort_q, load_q, incr_q, user_q, sbit_q, wb_q, m32_q;
    logic [MODE_W-1:0] mode_q;

    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any;
    logic [AW-1:0]     step_addr;
    logic [NREGS-1:0]  pend_after;
    logic              accept, take_abort, take_ok, is_last;
    logic [MODE_W-1:0] bank;
    logic              pc_partial;
    logic [DW-1:0]     merged;

    ldm_pick #(.NREGS(NREGS)) u_pick (
        .mask  (pend_q),
        .ascend(incr_q),
        .idx   (cur_idx),
        .any   (cur_any)
    );

    assign pc_partial = load_q && (cur_idx == IDX_W'(PC_IDX)) && !sbit_q && !m32_q;

    ldm_pc_merge #(.DW(DW), .PC_MASK(PC_MASK)) u_merge (
        .partial(pc_partial),
        .old_val(rf_rd_data),
        .new_val(mem_rdata),
        .merged (merged)
    );

    assign step_addr  = incr_q ? (addr_q + AW'(STEP)) : (addr_q - AW'(STEP));
    assign pend_after = pend_q & ~(NREGS'(1) << cur_idx);
    assign accept     = (state_q == ST_XFER) && mem_ready;
    assign take_abort = accept && mem_abort;
    assign take_ok    = accept && !mem_abort;
    assign is_last    = (pend_after == '0);
    assign bank       = user_q ? MODE_W'(USER_MODE) : mode_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (|reg_list) ? ST_XFER : ST_DONE;
            ST_XFER: if (take_abort || (take_ok && is_last)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            abort_q <= 1'b0;
            load_q  <= 1'b0;
            incr_q  <= 1'b0;
            user_q  <= 1'b0;
            sbit_q  <= 1'b0;
            wb_q    <= 1'b0;
            m32_q   <= 1'b0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                pend_q  <= reg_list;
                addr_q  <= base_addr;
                cnt_q   <= '0;
                abort_q <= 1'b0;
                load_q  <= op_load;
                incr_q  <= op_incr;
                user_q  <= op_user && !reg_list[PC_IDX];
                sbit_q  <= op_user;
                wb_q    <= op_wb;
                m32_q   <= mode32;
                mode_q  <= cur_mode;
            end else if (take_abort) begin
                abort_q <= 1'b1;
                pend_q  <= '0;
            end else if (take_ok) begin
                pend_q <= pend_after;
                addr_q <= step_addr;
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state_q == ST_XFER) && cur_any;
        mem_we     = mem_req && !load_q;
        mem_addr   = step_addr;
        mem_wdata  = rf_rd_data;
        rf_rd_idx  = cur_idx;
        rf_rd_mode = bank;
        rf_wr_en   = take_ok && load_q;
        rf_wr_idx  = cur_idx;
        rf_wr_mode = bank;
        rf_wr_data = merged;
        done       = (state_q == ST_DONE);
        aborted    = done && abort_q;
        xfer_count = cnt_q;
        wb_en      = done && wb_q && !abort_q;
        wb_addr    = addr_q;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_rd_idx) && $stable(mem_we)));

    // R1
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_abort && incr_q && !is_last) |=> (mem_addr == $past(mem_addr) + AW'(STEP)));

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_abort && !incr_q && !is_last) |=> (mem_addr == $past(mem_addr) - AW'(STEP)));

    // R5
    abort_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_abort) |-> !rf_wr_en);

    // R5
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_abort) |=> (done && aborted && !mem_req));

    // R6
    wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !aborted));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xfer_count <= CNT_W'(NREGS)));
endmodule

// File: tb/ldm_seq_bench.sv
module ldm_seq_bench;
    localparam logic [31:0] MASK = 32'h03FF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_load = 1'b0, op_incr = 1'b0, op_user = 1'b0, op_wb = 1'b0, mode32 = 1'b0;
    logic [15:0] reg_list = '0;
    logic [31:0] base_addr = '0;
    logic [4:0]  cur_mode = 5'h13;
    logic [3:0]  rf_rd_idx, rf_wr_idx;
    logic [4:0]  rf_rd_mode, rf_wr_mode;
    logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, wb_addr;
    logic        rf_wr_en, mem_req, mem_we, done, aborted, wb_en;
    logic        mem_ready = 1'b0, mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  xfer_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] rfval(input logic [3:0] idx, input logic [4:0] mode);
        return 32'hF000_0003 ^ (32'({mode, idx}) << 8);
    endfunction

    assign rf_rd_data = rfval(rf_rd_idx, rf_rd_mode);

    ldm_seq u_ldm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load), .op_incr(op_incr),
        .op_user(op_user), .op_wb(op_wb), .mode32(mode32), .reg_list(reg_list),
        .base_addr(base_addr), .cur_mode(cur_mode),
        .rf_rd_idx(rf_rd_idx), .rf_rd_mode(rf_rd_mode), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_mode(rf_wr_mode), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_abort(mem_abort),
        .done(done), .aborted(aborted), .xfer_count(xfer_count), .wb_en(wb_en), .wb_addr(wb_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // run one transfer; abort_pos < 0 means no abort
    task automatic run(input bit ld, input bit inc, input bit usr, input bit wb, input bit m32,
                       input logic [15:0] lst, input logic [31:0] base, input logic [4:0] md,
                       input int abort_pos);
        logic [3:0]  exp_idx[16];
        int          n = 0;
        int          k = 0;
        int          cyc = 0;
        bit          ab = 0;
        logic [4:0]  bank;
        logic [31:0] ea, ed, rd;
        for (int i = 0; i < 16; i++) begin
            int j = inc ? i : 15 - i;
            if (lst[j]) begin exp_idx[n] = 4'(j); n++; end
        end
        if (abort_pos >= n) abort_pos = -1;
        bank = (usr && !lst[15]) ? 5'h10 : md;
        @(negedge clk);
        start = 1; op_load = ld; op_incr = inc; op_user = usr; op_wb = wb; mode32 = m32;
        reg_list = lst; base_addr = base; cur_mode = md;
        @(negedge clk);
        start = 0; reg_list = $urandom; base_addr = $urandom; cur_mode = 5'h1F;
        forever begin
            mem_ready = 0; mem_abort = 0;
            #1;
            if (done) begin
                chk(k == (ab ? abort_pos + 1 : n), "R3 request count", 32'(k), 32'(n));
                chk(xfer_count == 5'(ab ? abort_pos : n), "R9 xfer_count", 32'(xfer_count), 32'(ab ? abort_pos : n));
                chk(aborted == ab, "R5 aborted flag", 32'(aborted), 32'(ab));
                chk(wb_en == (wb && !ab), "R6 wb_en", 32'(wb_en), 32'(wb && !ab));
                if (wb && !ab) begin
                    ea = inc ? base + 32'(4 * n) : base - 32'(4 * n);
                    chk(wb_addr == ea, "R6 wb_addr", wb_addr, ea);
                end
                if (n == 0) chk(cyc == 0 && !mem_req, "R10 empty list done next cycle", 32'(cyc), 0);
                @(negedge clk);
                #1;
                chk(!done, "R11 done single pulse", 32'(done), 0);
                break;
            end
            if (ab) begin
                chk(0, "R5 done after abort", 32'(done), 1);
                break;
            end
            if (mem_req) begin
                if (k >= n) begin
                    chk(0, "R3 extra request", 32'(k), 32'(n));
                    break;
                end
                ea = inc ? base + 32'(4 * (k + 1)) : base - 32'(4 * (k + 1));
                chk(rf_rd_idx == exp_idx[k], inc ? "R1 index order" : "R2 index order", 32'(rf_rd_idx), 32'(exp_idx[k]));
                chk(mem_addr == ea, inc ? "R1 address" : "R2 address", mem_addr, ea);
                chk(rf_rd_mode == bank, "R7 bank", 32'(rf_rd_mode), 32'(bank));
                chk(mem_we == !ld, "R4 mem_we", 32'(mem_we), 32'(!ld));
                if (!ld) chk(mem_wdata == rfval(exp_idx[k], bank), "R4 store data", mem_wdata, rfval(exp_idx[k], bank));
                mem_ready = ($urandom % 4) != 0;
                mem_abort = mem_ready && (k == abort_pos);
                rd = $urandom;
                mem_rdata = rd;
                #1;
                if (mem_ready) begin
                    if (ld && !mem_abort) begin
                        ed = (exp_idx[k] == 4'd15 && !usr && !m32) ?
                             ((rfval(4'd15, bank) & ~MASK) | (rd & MASK)) : rd;
                        chk(rf_wr_en && rf_wr_idx == exp_idx[k], "R4 load write strobe", 32'(rf_wr_idx), 32'(exp_idx[k]));
                        chk(rf_wr_data == ed, exp_idx[k] == 4'd15 ? "R8 pc load data" : "R4 load data", rf_wr_data, ed);
                        chk(rf_wr_mode == bank, "R7 write bank", 32'(rf_wr_mode), 32'(bank));
                    end else begin
                        chk(!rf_wr_en, mem_abort ? "R5 no write on abort" : "R4 no write on store", 32'(rf_wr_en), 0);
                    end
                    if (mem_abort) ab = 1;
                    k++;
                end else begin
                    chk(!rf_wr_en, "R3 no write while stalled", 32'(rf_wr_en), 0);
                end
            end else begin
                chk(0, "R3 stalled without request", 0, 1);
                break;
            end
            cyc++;
            @(negedge clk);
        end
        mem_ready = 0; mem_abort = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(!done && !mem_req && !rf_wr_en, "R11 quiet in reset", 32'({done, mem_req, rf_wr_en}), 0);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(!done && !mem_req && !rf_wr_en, "R11 quiet after reset", 32'({done, mem_req, rf_wr_en}), 0);

        // directed corners
        run(1, 1, 0, 1, 0, 16'h0000, 32'h0000_1000, 5'h13, -1);   // R10 empty
        run(1, 1, 0, 1, 0, 16'hFFFF, 32'h0000_2000, 5'h13, -1);   // R8 full load, 26-bit
        run(1, 0, 0, 1, 1, 16'h8001, 32'h0000_3000, 5'h13, -1);   // R8 32-bit whole word
        run(1, 1, 1, 0, 0, 16'h8010, 32'h0000_4000, 5'h12, -1);   // R7/R8 S with R15
        run(0, 1, 1, 1, 0, 16'h00F0, 32'h0000_5000, 5'h13, -1);   // R7 user bank store
        run(1, 1, 0, 1, 0, 16'h0F0F, 32'h0000_6000, 5'h13, 0);    // R5 abort first
        run(1, 0, 0, 1, 0, 16'hA5A5, 32'h0000_7000, 5'h11, 4);    // R5 abort middle, wb blocked
        run(1, 1, 0, 1, 0, 16'h8003, 32'h0000_8000, 5'h13, 2);    // R5 abort on R15
        run(0, 0, 0, 1, 0, 16'h1248, 32'h0000_0008, 5'h13, -1);   // R2 store wrap below zero

        // random mix
        for (int t = 0; t < 300; t++) begin
            int ap = (($urandom % 3) == 0) ? int'($urandom % 17) : -1;
            logic [15:0] l = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
            run($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                l, $urandom, 5'($urandom), ap);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule